// File: doc/BRIEF.md
# Thread-Partitioned Victim Selector for a Four-Way Cache

This block picks which line of a four-way set-associative instruction cache is replaced on a miss. It also keeps the recency state that guides that choice. The four ways form two banks of two ways each: ways 0 and 1 form the left bank, and ways 2 and 3 form the right bank. Bit 0 of the requesting thread's identifier chooses the bank. Each cache line therefore competes only with the lines owned by threads of the same parity. This keeps one thread's refills from pushing out the code that another thread is still running.

Inside the chosen bank, one recency bit per set and per bank names the older of the two ways. An empty way in the bank is always used before a valid one. The victim output is combinational, so the cache controller can drive its tag and data writes in the same cycle it asks. Hits and fills update the recency bit of the affected bank at the next clock edge. The stored bits of the addressed set can be read on an output.

Top module: `tpv_victim_sel`

## Requirements
- R1: `victim_way[1]` always equals `thread_id[0]`. Thread bit 0 = 0 gives ways 0–1 (left bank), and 1 gives ways 2–3 (right bank).
- R2: When both ways of the chosen bank are valid, `victim_way` is the bank base plus the stored bit of that bank for `set_idx`. Bit value 0 means the lower way is the older one.
- R3: An invalid way in the chosen bank is chosen before the recency bit is consulted. The lower invalid way comes first, then the upper one.
- R4: A cycle with `access` and `hit` high sets the bit of bank `hit_way[1]` in set `set_idx` to `~hit_way[0]` at the next edge.
- R5: A cycle with `fill` high sets the bit of the chosen bank in set `set_idx` to `~victim_way[0]` at the next edge.
- R6: When a fill and a hit address the same bank in one cycle, the fill value is stored. When they address different banks, both updates take effect.
- R7: A cycle without hit or fill changes no state. An update touches only its own set and bank.
- R8: Synchronous active-high `rst` clears every stored bit to 0. `lru_bits` shows the stored bits of `set_idx`, with bit b belonging to bank b.
- R9: Identifier bits above bit 0 have no effect on the victim or on any update.
- R10: `victim_way` and `lru_bits` follow their inputs within the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | SET_W | Set addressed this cycle |
| access | input | 1 | A lookup completes this cycle |
| hit | input | 1 | The lookup hit |
| hit_way | input | 2 | Way that hit |
| thread_id | input | TID_W | Identifier of the requesting thread |
| way_valid | input | 4 | Valid bits of the four ways of the set |
| fill | input | 1 | Refill of the victim way is written this cycle |
| victim_way | output | 2 | Way to replace |
| lru_bits | output | 2 | Stored recency bits of the addressed set, one per bank |

## Verification
The bench builds the block with 8 sets and a 2-bit thread identifier. With only 8 sets, random traffic returns to the same set every few cycles. Hits, fills and combined hit-plus-fill cycles therefore build up on each other instead of landing in fresh sets. The 2-bit identifier keeps an upper bit that should be ignored, so the bench can check that identifiers of the same parity behave identically.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

    localparam int NUM_WAYS   = 4;
    localparam int NUM_BANKS  = 2;
    localparam int BANK_WAYS  = NUM_WAYS / NUM_BANKS;

    // A way number split into the bank it lives in and its slot in that bank.
    typedef struct packed {
        logic bank;
        logic slot;
    } way_sel_t;

    // Write request for one bank's recency bit.
    typedef struct packed {
        logic en;
        logic val;
    } bank_wr_t;

    // Slot choice within one bank: empty ways first, then the older way.
    function automatic logic pick_slot(input logic vld_lo, input logic vld_hi,
                                       input logic older);
        logic s;
        if (!vld_lo)      s = 1'b0;
        else if (!vld_hi) s = 1'b1;
        else              s = older;
        return s;
    endfunction

endpackage

// File: rtl/tpv_victim_pick.sv
module tpv_victim_pick
    import tpv_pkg::*;
(
    input  logic                 bank_sel,
    input  logic [NUM_WAYS-1:0]  way_valid,
    input  logic [NUM_BANKS-1:0] lru_bits,
    output way_sel_t             victim
);

    logic [NUM_BANKS-1:0] cand_slot;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            cand_slot[b] = pick_slot(way_valid[b*BANK_WAYS],
                                     way_valid[b*BANK_WAYS+1],
                                     lru_bits[b]);
        end
    end

    always_comb begin
        victim.bank = bank_sel;
        victim.slot = cand_slot[bank_sel];
    end

endmodule

// File: rtl/tpv_update_ctl.sv
module tpv_update_ctl
    import tpv_pkg::*;
(
    input  logic                 access,
    input  logic                 hit,
    input  way_sel_t             hit_way,
    input  logic                 fill,
    input  way_sel_t             victim,
    output bank_wr_t [NUM_BANKS-1:0] wr
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_here;
        logic fill_here;
        always_comb begin
            hit_here  = access && hit && (hit_way.bank == 1'(b));
            fill_here = fill && (victim.bank == 1'(b));
            wr[b].en  = hit_here || fill_here;
            // The fill result wins when both touch this bank.
            wr[b].val = fill_here ? ~victim.slot : ~hit_way.slot;
        end
    end

endmodule

// File: rtl/tpv_lru_store.sv
module tpv_lru_store
    import tpv_pkg::*;
#(
    parameter int NUM_SETS = 64,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SET_W-1:0]              set_idx,
    input  bank_wr_t [NUM_BANKS-1:0]      wr,
    output logic [NUM_BANKS-1:0]          rd_bits,
    output logic [NUM_SETS*NUM_BANKS-1:0] state_flat
);

    logic [NUM_BANKS-1:0] st [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic sel;
        assign sel = (set_idx == SET_W'(s));
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst)
                    st[s][b] <= 1'b0;
                else if (sel && wr[b].en)
                    st[s][b] <= wr[b].val;
            end
        end
        assign state_flat[s*NUM_BANKS +: NUM_BANKS] = st[s];
    end

    always_comb begin
        rd_bits = '0;
        for (int s = 0; s < NUM_SETS; s++)
            if (set_idx == SET_W'(s))
                rd_bits = st[s];
    end

endmodule

// File: rtl/tpv_victim_sel.sv
module tpv_victim_sel
    import tpv_pkg::*;
#(
    parameter int NUM_SETS = 64,
    parameter int TID_W    = 3,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SET_W-1:0]     set_idx,
    input  logic                 access,
    input  logic                 hit,
    input  logic [1:0]           hit_way,
    input  logic [TID_W-1:0]     thread_id,
    input  logic [NUM_WAYS-1:0]  way_valid,
    input  logic                 fill,
    output logic [1:0]           victim_way,
    output logic [NUM_BANKS-1:0] lru_bits
);

    logic                          bank_sel;
    logic                          unused_tid_hi;
    way_sel_t                      victim;
    way_sel_t                      hit_sel;
    bank_wr_t [NUM_BANKS-1:0]      wr;
    logic [NUM_SETS*NUM_BANKS-1:0] lru_state_flat;

    assign bank_sel      = thread_id[0];
    assign unused_tid_hi = ^thread_id[TID_W-1:1];
    assign hit_sel       = way_sel_t'(hit_way);

    tpv_lru_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .set_idx    (set_idx),
        .wr         (wr),
        .rd_bits    (lru_bits),
        .state_flat (lru_state_flat)
    );

    tpv_victim_pick u_pick (
        .bank_sel  (bank_sel),
        .way_valid (way_valid),
        .lru_bits  (lru_bits),
        .victim    (victim)
    );

    tpv_update_ctl u_upd (
        .access  (access),
        .hit     (hit),
        .hit_way (hit_sel),
        .fill    (fill),
        .victim  (victim),
        .wr      (wr)
    );

    assign victim_way = victim;

endmodule

// File: rtl/tpv_victim_sel_chk.sv
module tpv_victim_sel_chk #(
    parameter int NUM_SETS = 64,
    parameter int TID_W    = 3,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [SET_W-1:0]      set_idx,
    input logic                  access,
    input logic                  hit,
    input logic [1:0]            hit_way,
    input logic [TID_W-1:0]      thread_id,
    input logic [3:0]            way_valid,
    input logic                  fill,
    input logic [1:0]            victim_way,
    input logic [1:0]            lru_bits,
    input logic [NUM_SETS*2-1:0] lru_state_flat
);

    logic             rst_d;
    logic             hit_pend, fill_pend;
    logic [SET_W:0]   hit_idx, fill_idx;
    logic             hit_val, fill_val;
    logic             same_bank;

    assign same_bank = fill && (thread_id[0] == hit_way[1]);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            hit_pend  <= 1'b0;
            fill_pend <= 1'b0;
            hit_idx   <= '0;
            fill_idx  <= '0;
            hit_val   <= 1'b0;
            fill_val  <= 1'b0;
        end else begin
            hit_pend  <= access && hit && !same_bank;
            hit_idx   <= {set_idx, hit_way[1]};
            hit_val   <= ~hit_way[0];
            fill_pend <= fill;
            fill_idx  <= {set_idx, thread_id[0]};
            fill_val  <= ~victim_way[0];
        end
    end

    // R1
    p_bank_by_thread_r1: assert property (@(posedge clk) disable iff (rst)
        victim_way[1] == thread_id[0]);

    // R2
    p_older_way_r2: assert property (@(posedge clk) disable iff (rst)
        (way_valid[{thread_id[0], 1'b0}] && way_valid[{thread_id[0], 1'b1}])
        |-> victim_way[0] == lru_bits[thread_id[0]]);

    // R3
    p_empty_first_r3: assert property (@(posedge clk) disable iff (rst)
        !way_valid[{thread_id[0], 1'b0}] |-> victim_way[0] == 1'b0);

    // R4
    p_hit_update_r4: assert property (@(posedge clk) disable iff (rst)
        hit_pend |-> lru_state_flat[hit_idx] == hit_val);

    // R5
    p_fill_update_r5: assert property (@(posedge clk) disable iff (rst)
        fill_pend |-> lru_state_flat[fill_idx] == fill_val);

    // R8
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> lru_state_flat == '0);

endmodule

bind tpv_victim_sel tpv_victim_sel_chk #(
    .NUM_SETS (NUM_SETS),
    .TID_W    (TID_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .set_idx        (set_idx),
    .access         (access),
    .hit            (hit),
    .hit_way        (hit_way),
    .thread_id      (thread_id),
    .way_valid      (way_valid),
    .fill           (fill),
    .victim_way     (victim_way),
    .lru_bits       (lru_bits),
    .lru_state_flat (lru_state_flat)
);

// File: tb/tpv_victim_sel_bench.sv
`timescale 1ns/1ps
module tpv_victim_sel_bench;

    localparam int NSETS = 8;
    localparam int TIDW  = 2;
    localparam int SW    = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [SW-1:0]   set_idx = '0;
    logic            access = 1'b0;
    logic            hit = 1'b0;
    logic [1:0]      hit_way = '0;
    logic [TIDW-1:0] thread_id = '0;
    logic [3:0]      way_valid = '0;
    logic            fill = 1'b0;
    logic [1:0]      victim_way;
    logic [1:0]      lru_bits;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [1:0] m_lru [NSETS];

    always #4 clk = ~clk;

    tpv_victim_sel #(.NUM_SETS(NSETS), .TID_W(TIDW)) u_tpv_victim_sel (
        .clk(clk), .rst(rst), .set_idx(set_idx), .access(access), .hit(hit),
        .hit_way(hit_way), .thread_id(thread_id), .way_valid(way_valid),
        .fill(fill), .victim_way(victim_way), .lru_bits(lru_bits)
    );

    function automatic logic [1:0] exp_victim(input logic [1:0] bits,
                                              input logic [TIDW-1:0] tid,
                                              input logic [3:0] vld);
        logic b;
        logic s;
        b = tid[0];
        if (!vld[{b, 1'b0}])      s = 1'b0;
        else if (!vld[{b, 1'b1}]) s = 1'b1;
        else                      s = bits[b];
        return {b, s};
    endfunction

    task automatic check2(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive one cycle, check combinational outputs, then apply the model update.
    task automatic step(input string req, input logic [SW-1:0] s,
                        input logic a, input logic h, input logic [1:0] hw,
                        input logic [TIDW-1:0] t, input logic [3:0] v,
                        input logic f);
        logic [1:0] ev;
        @(negedge clk);
        set_idx = s; access = a; hit = h; hit_way = hw;
        thread_id = t; way_valid = v; fill = f;
        #1;
        ev = exp_victim(m_lru[s], t, v);
        check2(req, "victim_way", victim_way, ev);
        check2(req, "lru_bits", lru_bits, m_lru[s]);
        @(posedge clk);
        if (a && h && !(f && hw[1] == t[0]))
            m_lru[s][hw[1]] = ~hw[0];
        if (f)
            m_lru[s][t[0]] = ~ev[0];
    endtask

    task automatic idle_read(input string req, input logic [SW-1:0] s,
                             input logic [TIDW-1:0] t);
        step(req, s, 1'b0, 1'b0, 2'd0, t, 4'hF, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NSETS; i++) m_lru[i] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: every set reads zero after reset; R2 then picks the lower way.
        for (int i = 0; i < NSETS; i++) idle_read("R8", SW'(i), 2'd0);
        idle_read("R1", 3'd0, 2'd1);

        // R3: empty ways come first, lower before upper.
        step("R3", 3'd1, 1'b0, 1'b0, 2'd0, 2'd1, 4'b1011, 1'b0);
        step("R3", 3'd1, 1'b0, 1'b0, 2'd0, 2'd1, 4'b0111, 1'b0);
        step("R3", 3'd1, 1'b0, 1'b0, 2'd0, 2'd1, 4'b0011, 1'b0);
        step("R3", 3'd1, 1'b0, 1'b0, 2'd0, 2'd0, 4'b1101, 1'b0);

        // R4: hits move the bank's bit away from the hit way.
        step("R4", 3'd2, 1'b1, 1'b1, 2'd0, 2'd0, 4'hF, 1'b0);
        idle_read("R4", 3'd2, 2'd0);
        step("R4", 3'd2, 1'b1, 1'b1, 2'd2, 2'd0, 4'hF, 1'b0);
        idle_read("R4", 3'd2, 2'd1);
        step("R4", 3'd2, 1'b1, 1'b1, 2'd1, 2'd1, 4'hF, 1'b0);
        idle_read("R2", 3'd2, 2'd0);

        // R5: a fill marks the filled way as recent.
        step("R5", 3'd3, 1'b0, 1'b0, 2'd0, 2'd1, 4'hF, 1'b1);
        idle_read("R5", 3'd3, 2'd1);
        step("R5", 3'd3, 1'b0, 1'b0, 2'd0, 2'd1, 4'b0111, 1'b1);
        idle_read("R5", 3'd3, 2'd1);

        // R6: same-bank conflict stores the fill, cross-bank applies both.
        step("R6", 3'd4, 1'b1, 1'b1, 2'd1, 2'd0, 4'hF, 1'b1);
        idle_read("R6", 3'd4, 2'd0);
        step("R6", 3'd5, 1'b1, 1'b1, 2'd3, 2'd0, 4'hF, 1'b1);
        idle_read("R6", 3'd5, 2'd0);

        // R7: a miss with no fill changes nothing; neighbours untouched.
        step("R7", 3'd5, 1'b1, 1'b0, 2'd2, 2'd1, 4'hF, 1'b0);
        idle_read("R7", 3'd5, 2'd1);
        idle_read("R7", 3'd6, 2'd0);
        idle_read("R7", 3'd4, 2'd1);

        // R9: thread identifiers of equal parity behave the same.
        step("R9", 3'd6, 1'b0, 1'b0, 2'd0, 2'd2, 4'hF, 1'b1);
        idle_read("R9", 3'd6, 2'd0);
        step("R9", 3'd6, 1'b0, 1'b0, 2'd0, 2'd3, 4'hF, 1'b1);
        idle_read("R9", 3'd6, 2'd3);

        // R10: random traffic, outputs checked in the cycle the inputs change.
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] v;
            v = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            step("R10", SW'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), TIDW'($urandom), v, ($urandom % 3) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end

endmodule